// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter Stage

This block is a small up-counter stage that steps through its values in binary order on the rising clock edge and rolls over to zero after its highest value. The default width is 4 bits, so one stage counts modulo 16. It can be preset from a data word. Two count-enable inputs, a parallel one and a trickle one, must both be high for the stage to advance. A combinational terminal-count output lets a stage hand the count onward to the next stage with no extra logic in between.

A build-time parameter picks how the active-low clear acts. In the asynchronous style it empties the counter at once, with no clock edge needed. In the synchronous style it takes effect on the next rising edge. Several stages chain into one wider counter. Each stage's terminal count feeds the trickle enable of the stage above it. The lowest stage's enables act as the enable for the whole chain.

Top module: `pcnt_stage`

## Requirements
- R1: When counting, the value after the all-ones state (15 at the default width) is 0.
- R2: With clear_n high, load_n high, and both en_par and en_trk high, each rising clock edge adds one to cnt.
- R3: With clear_n and load_n high, cnt keeps its value across an edge if en_par or en_trk is low.
- R4: With clear_n high and load_n low, the next rising edge copies din into cnt, whatever the enables are.
- R5: With ASYNC_CLR=0, a low clear_n leaves cnt unchanged until the next rising edge, which sets cnt to 0 regardless of load_n and the enables. With either setting, cnt reads 0 when clear_n has just been released.
- R6: With ASYNC_CLR=1, a low clear_n sets cnt to 0 at once, with no clock edge, and keeps it at 0 across edges while it stays low.
- R7: tc is high exactly when cnt is all ones and en_trk is high. It does not depend on en_par. A change on en_trk reaches tc in the same cycle.
- R8: A loaded value, including all ones, is the starting point for counting on the following edges. A load of 15 followed by one count gives 0.
- R9: Three stages chained through tc into en_trk count as one 12-bit binary counter. This includes carries across stage boundaries and holding when the global enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clear_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low preset request |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also qualifies tc |
| din | input | WIDTH | Preset data |
| cnt | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: all ones and en_trk high |

## Verification
A long free-running count separates correct increment and rollover from off-by-one or saturating behaviour. Holds with each enable low in turn show that both enables gate the count and that only the trickle enable gates tc. Loads made while both enables are high show that preset takes priority over counting. Clears asserted with load and count requests active show that clear takes priority. Sampling between edges tells the synchronous clear apart from the asynchronous one. A 12-bit chain preset near its carry points shows whether tc lines up with the next stage's trickle enable.

// File: rtl/pcnt_pkg.sv
`timescale 1ns/1ps
package pcnt_pkg;
  // Operating mode chosen for the coming edge, highest priority first.
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_HOLD  = 2'd3
  } pcnt_mode_e;
endpackage

// File: rtl/pcnt_mode_dec.sv
`timescale 1ns/1ps
module pcnt_mode_dec
  import pcnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic       clear_n,
  input  logic       load_n,
  input  logic       en_par,
  input  logic       en_trk,
  output pcnt_mode_e mode
);
  // With the asynchronous clear the register itself empties the count,
  // so the decoder never has to pick the clear mode.
  logic sync_clear;

  generate
    if (ASYNC_CLR) begin : g_async
      assign sync_clear = 1'b0;
    end else begin : g_sync
      assign sync_clear = ~clear_n;
    end
  endgenerate

  always_comb begin
    if (sync_clear)             mode = MODE_CLEAR;
    else if (!load_n)           mode = MODE_LOAD;
    else if (en_par && en_trk)  mode = MODE_COUNT;
    else                        mode = MODE_HOLD;
  end
endmodule

// File: rtl/pcnt_next.sv
`timescale 1ns/1ps
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  pcnt_mode_e       mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = cur + ONE;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcnt_tc.sv
`timescale 1ns/1ps
module pcnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);
  logic at_top;
  assign at_top = &cur;
  assign tc     = at_top & en_trk;
endmodule

// File: rtl/pcnt_stage.sv
`timescale 1ns/1ps
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  pcnt_mode_e       mode;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;

  pcnt_mode_dec #(.ASYNC_CLR(ASYNC_CLR)) u_dec (
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .mode    (mode)
  );

  pcnt_next #(.WIDTH(WIDTH)) u_next (
    .mode (mode),
    .cur  (q),
    .din  (din),
    .nxt  (q_nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_areg
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= q_nxt;
      end
    end else begin : g_sreg
      always_ff @(posedge clk) begin
        q <= q_nxt;
      end
    end
  endgenerate

  pcnt_tc #(.WIDTH(WIDTH)) u_tc (
    .cur    (q),
    .en_trk (en_trk),
    .tc     (tc)
  );

  assign cnt = q;

  // R2: counting adds one
  a_r2_increment: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk) |=> (cnt == $past(cnt) + 1'b1));

  // R1: all ones rolls over to zero
  a_r1_rollover: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk && cnt == ALL_ONES) |=> (cnt == '0));

  // R3: either enable low holds the count
  a_r3_hold: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_par && en_trk)) |=> $stable(cnt));

  // R4: preset wins over counting
  a_r4_load: assert property (@(posedge clk) disable iff (!clear_n)
    (!load_n) |=> (cnt == $past(din)));

  // R5: count is empty once the clear is released
  a_r5_clear_done: assert property (@(posedge clk) disable iff (!clear_n)
    $rose(clear_n) |-> (cnt == '0));

  // R7: terminal count requires the trickle enable
  a_r7_tc_needs_trk: assert property (@(posedge clk) disable iff (!clear_n)
    tc |-> (en_trk && cnt == ALL_ONES));
endmodule

// File: tb/sim_pcnt_stage.sv
`timescale 1ns/1ps
module pcnt_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic              load_n,
  input  logic              en,
  input  logic [4*STAGES-1:0] din,
  output logic [4*STAGES-1:0] cnt,
  output logic              tc
);
  logic [STAGES:0] carry;
  assign carry[0] = en;

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    pcnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_st (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_par  (en),
      .en_trk  (carry[s]),
      .din     (din[4*s +: 4]),
      .cnt     (cnt[4*s +: 4]),
      .tc      (carry[s+1])
    );
  end
  assign tc = carry[STAGES];
endmodule

module sim_pcnt_stage;
  logic       clk = 1'b0;
  logic       clr_s = 1'b0;
  logic       clr_a = 1'b0;
  logic       load_n = 1'b1;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt0, cnt1;
  logic       tc0, tc1;

  logic        ch_clr = 1'b0;
  logic        ch_load = 1'b1;
  logic        ch_en = 1'b0;
  logic [11:0] ch_din = 12'd0;
  logic [11:0] ch_cnt;
  logic        ch_tc;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .clear_n(clr_s), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .cnt(cnt0), .tc(tc0));

  pcnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .clear_n(clr_a), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .cnt(cnt1), .tc(tc1));

  pcnt_chain #(.STAGES(3)) u_chain (
    .clk(clk), .clear_n(ch_clr), .load_n(ch_load), .en(ch_en),
    .din(ch_din), .cnt(ch_cnt), .tc(ch_tc));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one rising edge and settle 1 ns after it.
  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clr_s = 1'b0; clr_a = 1'b0; ch_clr = 1'b0;
    load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
    repeat (3) edge1();
    chk("R5 reset cnt sync", cnt0, 0);
    chk("R6 reset cnt async", cnt1, 0);
    chk("R7 reset tc", tc0, 0);
    chk("R9 reset chain", ch_cnt, 0);
    clr_s = 1'b1; clr_a = 1'b1; ch_clr = 1'b1;
    en_par = 1'b0; en_trk = 1'b0;
    edge1();
    chk("R5 held after release", cnt0, 0);
  endtask

  task automatic t_count();
    int exp = 0;
    en_par = 1'b1; en_trk = 1'b1; load_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      edge1();
      exp = (exp + 1) % 16;
      chk(exp == 0 ? "R1 rollover" : "R2 increment", cnt0, exp);
      chk("R7 tc while counting", tc0, (exp == 15) ? 1 : 0);
    end
  endtask

  task automatic t_hold();
    int base;
    base = cnt0;
    en_par = 1'b0; en_trk = 1'b1;
    repeat (3) edge1();
    chk("R3 hold en_par low", cnt0, base);
    en_par = 1'b1; en_trk = 1'b0;
    repeat (3) edge1();
    chk("R3 hold en_trk low", cnt0, base);
    // bring to 15 by load, then probe tc with enables
    din = 4'd15; load_n = 1'b0; en_par = 1'b0; en_trk = 1'b0;
    edge1();
    load_n = 1'b1;
    chk("R4 load with enables low", cnt0, 15);
    chk("R7 tc low with en_trk low", tc0, 0);
    en_trk = 1'b1; #1;
    chk("R7 tc follows en_trk same cycle, en_par low", tc0, 1);
    en_trk = 1'b0; #1;
    chk("R7 tc drops with en_trk", tc0, 0);
    edge1();
    chk("R3 hold at 15", cnt0, 15);
  endtask

  task automatic t_load();
    en_par = 1'b1; en_trk = 1'b1;
    din = 4'd9; load_n = 1'b0;
    edge1();
    chk("R4 load wins over count", cnt0, 9);
    edge1();
    chk("R4 repeated load", cnt0, 9);
    din = 4'd15;
    edge1();
    load_n = 1'b1;
    chk("R8 load of 15", cnt0, 15);
    chk("R7 tc after load 15", tc0, 1);
    edge1();
    chk("R8 count resumes from loaded 15", cnt0, 0);
    edge1();
    chk("R8 next count", cnt0, 1);
  endtask

  task automatic t_sync_clr();
    din = 4'd6; load_n = 1'b0;
    edge1();
    chk("R4 preload 6", cnt0, 6);
    din = 4'd11; en_par = 1'b1; en_trk = 1'b1;
    clr_s = 1'b0; #3;
    chk("R5 no change before edge", cnt0, 6);
    edge1();
    chk("R5 clear wins over load", cnt0, 0);
    load_n = 1'b1;
    edge1();
    chk("R5 clear wins over count", cnt0, 0);
    clr_s = 1'b1;
    edge1();
    chk("R2 counts after clear", cnt0, 1);
  endtask

  task automatic t_async();
    din = 4'd12; load_n = 1'b0;
    edge1();
    load_n = 1'b1;
    chk("R4 async stage preload", cnt1, 12);
    @(negedge clk);
    clr_a = 1'b0; #2;
    chk("R6 immediate clear", cnt1, 0);
    load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1;
    edge1();
    chk("R6 stays clear across edge", cnt1, 0);
    load_n = 1'b1;
    clr_a = 1'b1;
    edge1();
    chk("R6 counts after release", cnt1, 1);
  endtask

  task automatic t_chain();
    int ref_v;
    ch_din = 12'hFFC; ch_load = 1'b0; ch_en = 1'b0;
    edge1();
    ch_load = 1'b1;
    ref_v = 'hFFC;
    chk("R9 chain load", ch_cnt, ref_v);
    ch_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      edge1();
      ref_v = (ref_v + 1) % 4096;
      chk("R9 chain count", ch_cnt, ref_v);
    end
    ch_din = 12'h0EE; ch_load = 1'b0;
    edge1();
    ch_load = 1'b1;
    ref_v = 'h0EE;
    for (int i = 0; i < 20; i++) begin
      edge1();
      ref_v = (ref_v + 1) % 4096;
      chk("R9 chain carry", ch_cnt, ref_v);
    end
    ch_en = 1'b0;
    repeat (3) edge1();
    chk("R9 chain hold", ch_cnt, ref_v);
  endtask

  initial begin
    #1;
    t_reset();
    t_count();
    t_hold();
    t_load();
    t_sync_clr();
    t_async();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule